// File: doc/BRIEF.md
# Extended Multiframe Overhead Bit Inserter

This block sits on the transmit side of a 1.544 Mbit/s framer. It builds the outgoing serial bit stream one bit at a time. Each frame is 193 bits long. The block places one overhead bit at the front of every frame and fills the other 192 positions from a serial payload source. Twenty-four frames make up one multiframe. The overhead bit of a frame takes one of three roles, decided by where the frame sits in the multiframe: multiframe alignment, a 4 kbit/s data-link bit, or one bit of a CRC-6 check word.

A line-rate strobe `bit_tick` marks each cycle in which one line bit must be produced. The payload side is a valid/ready stream. `pl_ready` is offered only in a strobe cycle that falls on a payload position. The line cannot wait, so back-pressure never stalls the block. If `pl_valid` is low when ready is offered, that position is filled with a 1, which counts as an underrun. The data-link side works the same way on the overhead positions of odd frames.

The CRC-6 is taken over every bit position of a multiframe, with each overhead position counted as 1. The result is sent in the multiframe that follows.

Top module: `esf_oh_inserter`

## Requirements
- R1: Every frame is 193 line bits. The first bit of each frame is the overhead bit, and `line_fbit` is 1 with that bit and only with it.
- R2: Twenty-four frames form a multiframe. `line_mf_start` is 1 only with the overhead bit of frame 1. After the last bit of frame 24, the next bit is the overhead bit of frame 1.
- R3: The overhead bits of frames 4, 8, 12, 16, 20 and 24 carry 0, 0, 1, 0, 1, 1 in that order.
- R4: The overhead bits of odd frames (1, 3, ..., 23) carry the data link. `dl_ready` pulses with `bit_tick` at those positions only. The bit sent is `dl_bit` when `dl_valid` is 1, and 1 otherwise.
- R5: `pl_ready` equals `bit_tick` on each of the 192 payload positions and is 0 on overhead positions. A payload position sends `pl_data` when `pl_valid` is 1, and 1 otherwise.
- R6: The overhead bits of frames 2, 6, 10, 14, 18 and 22 carry check bits e1..e6. These are the remainder of the previous multiframe's 4632 bits, first-sent bit as highest coefficient, multiplied by x^6 and divided by x^6+x+1. Overhead positions count as 1 in this sum. e1 is the remainder's x^5 coefficient.
- R7: The first multiframe after reset carries check bits of all zeros.
- R8: `line_valid` is 1 exactly one cycle after each `bit_tick`, and `line_bit`, `line_fbit` and `line_mf_start` belong to that tick. Without a tick, `line_valid` is 0 and the frame position holds.
- R9: While reset is held and after it is released, `line_valid` is 0. The first ticked bit after reset is the overhead bit of frame 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One line bit is due in this cycle |
| pl_valid | input | 1 | Payload bit present |
| pl_data | input | 1 | Payload bit |
| pl_ready | output | 1 | Payload bit taken in this cycle |
| dl_valid | input | 1 | Data-link bit present |
| dl_bit | input | 1 | Data-link bit |
| dl_ready | output | 1 | Data-link bit taken in this cycle |
| line_valid | output | 1 | Line bit valid |
| line_bit | output | 1 | Outgoing line bit |
| line_fbit | output | 1 | Line bit is an overhead bit |
| line_mf_start | output | 1 | Line bit is overhead bit of frame 1 |

## Verification
Two functions meet in one cycle at the last bit of frame 24. That payload bit must still be folded into the running CRC, and in the same edge the running value is handed to the hold register and cleared. The bench drives random payload, including underrun fills, across several multiframes, so that this closing bit takes both values. A bench model computes the remainder independently and compares it with the e1..e6 bits of the next multiframe. A lost or double-counted closing bit therefore shows up as a wrong check bit.

// File: rtl/esf_pkg.sv
package esf_pkg;
  localparam int FRAME_BITS = 193;
  localparam int MF_FRAMES  = 24;
  localparam int CRC_W      = 6;
  localparam logic [CRC_W-1:0] CRC_POLY = 6'b000011;
  localparam logic [5:0] ALIGN_SEQ = 6'b001011;

  typedef enum logic [1:0] {
    SLOT_PAYLOAD = 2'd0,
    SLOT_DLINK   = 2'd1,
    SLOT_CHECK   = 2'd2,
    SLOT_ALIGN   = 2'd3
  } slot_e;

  // frame_idx is zero-based: index 0 is frame 1
  function automatic slot_e classify(input logic is_first, input logic [4:0] frame_idx);
    if (!is_first)         return SLOT_PAYLOAD;
    else if (!frame_idx[0]) return SLOT_DLINK;
    else if (!frame_idx[1]) return SLOT_CHECK;
    else                    return SLOT_ALIGN;
  endfunction
endpackage

// File: rtl/esf_frame_ctr.sv
module esf_frame_ctr #(
  parameter int FRAME_BITS = 193,
  parameter int MF_FRAMES  = 24,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int FRM_W = $clog2(MF_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [POS_W-1:0] pos,
  output logic [FRM_W-1:0] frame,
  output logic             is_first,
  output logic             mf_last
);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(FRAME_BITS - 1);
  localparam logic [FRM_W-1:0] FRM_MAX = FRM_W'(MF_FRAMES - 1);

  assign is_first = (pos == '0);
  assign mf_last  = (pos == POS_MAX) && (frame == FRM_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      frame <= '0;
    end else if (adv) begin
      if (pos == POS_MAX) begin
        pos   <= '0;
        frame <= (frame == FRM_MAX) ? '0 : frame + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_MAX);  // R1
  AST_MF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && mf_last |=> pos == '0 && frame == '0);  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pos) && $stable(frame));  // R8
endmodule

// File: rtl/esf_crc6.sv
module esf_crc6 #(
  parameter int W = 6,
  parameter logic [W-1:0] POLY = 6'b000011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         din,
  input  logic         close,
  output logic [W-1:0] held
);
  logic [W-1:0] run_q;
  logic [W-1:0] nxt;
  logic         fb;

  assign fb = run_q[W-1] ^ din;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign nxt[i] = fb & POLY[i];
    end else begin : g_up
      assign nxt[i] = run_q[i-1] ^ (fb & POLY[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      held  <= '0;
    end else if (adv) begin
      if (close) begin
        held  <= nxt;
        run_q <= '0;
      end else begin
        run_q <= nxt;
      end
    end
  end

  AST_CRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    adv && close |=> run_q == '0);  // R6
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && close) |=> $stable(held));  // R6
endmodule

// File: rtl/esf_oh_inserter.sv
module esf_oh_inserter
  import esf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic pl_valid,
  input  logic pl_data,
  output logic pl_ready,
  input  logic dl_valid,
  input  logic dl_bit,
  output logic dl_ready,
  output logic line_valid,
  output logic line_bit,
  output logic line_fbit,
  output logic line_mf_start
);
  localparam int POS_W = $clog2(FRAME_BITS);
  localparam int FRM_W = $clog2(MF_FRAMES);

  logic [POS_W-1:0] pos;
  logic [FRM_W-1:0] frame;
  logic             is_first, mf_last;
  logic [CRC_W-1:0] chk_word;
  logic [2:0]       grp;
  slot_e            slot;
  logic             pay_bit, oh_bit, out_bit, crc_in;

  esf_frame_ctr #(.FRAME_BITS(FRAME_BITS), .MF_FRAMES(MF_FRAMES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .adv(bit_tick),
    .pos(pos), .frame(frame), .is_first(is_first), .mf_last(mf_last));

  esf_crc6 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .adv(bit_tick), .din(crc_in),
    .close(mf_last), .held(chk_word));

  assign grp     = frame[4:2];
  assign slot    = classify(is_first, 5'(frame));
  assign pay_bit = pl_valid ? pl_data : 1'b1;

  always_comb begin
    unique case (slot)
      SLOT_DLINK: oh_bit = dl_valid ? dl_bit : 1'b1;
      SLOT_CHECK: oh_bit = chk_word[3'd5 - grp];
      SLOT_ALIGN: oh_bit = ALIGN_SEQ[3'd5 - grp];
      default:    oh_bit = 1'b1;
    endcase
  end

  assign out_bit  = is_first ? oh_bit : pay_bit;
  assign crc_in   = is_first ? 1'b1 : pay_bit;
  assign pl_ready = bit_tick & ~is_first;
  assign dl_ready = bit_tick & (slot == SLOT_DLINK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_valid    <= 1'b0;
      line_bit      <= 1'b0;
      line_fbit     <= 1'b0;
      line_mf_start <= 1'b0;
    end else begin
      line_valid    <= bit_tick;
      line_bit      <= bit_tick & out_bit;
      line_fbit     <= bit_tick & is_first;
      line_mf_start <= bit_tick & is_first & (frame == '0);
    end
  end

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pl_ready && dl_ready));  // R5
  AST_DL_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    dl_ready |-> is_first && !frame[0]);  // R4
  AST_TICK_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> line_valid);  // R8
  AST_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> !line_valid);  // R8
  AST_MF_IS_F: assert property (@(posedge clk) disable iff (!rst_n)
    line_mf_start |-> line_fbit && line_valid);  // R2
endmodule

// File: tb/tb_esf_oh_inserter.sv
`timescale 1ns/1ps
module tb_esf_oh_inserter;
  logic clk = 0, rst_n = 0;
  logic bit_tick = 0, pl_valid = 0, pl_data = 0, dl_valid = 0, dl_bit = 0;
  logic pl_ready, dl_ready, line_valid, line_bit, line_fbit, line_mf_start;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  esf_oh_inserter dut (.*);

  // reference model state
  int m_pos = 0, m_frame = 0;
  logic [5:0] m_run = 0, m_held = 0;
  int mf_count = 0;
  logic e_valid = 0, e_bit = 0, e_f = 0, e_mf = 0;
  string e_tag = "R8";

  function automatic logic [5:0] crc_step(logic [5:0] r, logic d);
    logic f = r[5] ^ d;
    return {r[4], r[3], r[2], r[1], r[0] ^ f, f};
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b (frame %0d pos %0d)", tag, what, act, exp, m_frame, m_pos);
    end
  endtask

  task automatic step(input logic t, input logic pv, input logic pd, input logic dv, input logic db);
    logic exp_b, pay;
    string tag;
    @(negedge clk);
    // outputs from previous edge
    chk(line_valid, e_valid, "R8", "line_valid");
    if (e_valid) begin
      chk(line_bit, e_bit, e_tag, "line_bit");
      chk(line_fbit, e_f, "R1", "line_fbit");
      chk(line_mf_start, e_mf, "R2", "line_mf_start");
    end
    bit_tick = t; pl_valid = pv; pl_data = pd; dl_valid = dv; dl_bit = db;
    #1;
    chk(pl_ready, t && m_pos != 0, "R5", "pl_ready");
    chk(dl_ready, t && m_pos == 0 && (m_frame % 2 == 0), "R4", "dl_ready");
    e_valid = t;
    if (t) begin
      pay = pv ? pd : 1'b1;
      if (m_pos != 0) begin
        exp_b = pay; tag = "R5";
      end else if (m_frame % 2 == 0) begin
        exp_b = dv ? db : 1'b1; tag = "R4";
      end else if (m_frame % 4 == 1) begin
        exp_b = m_held[5 - m_frame / 4];
        tag = (mf_count == 0) ? "R7" : "R6";
      end else begin
        exp_b = 6'b001011 >> (5 - m_frame / 4); tag = "R3";
      end
      e_bit = exp_b; e_tag = tag; e_f = (m_pos == 0); e_mf = (m_pos == 0 && m_frame == 0);
      m_run = crc_step(m_run, (m_pos == 0) ? 1'b1 : pay);
      if (m_pos == 192) begin
        m_pos = 0;
        if (m_frame == 23) begin
          m_frame = 0; m_held = m_run; m_run = 0; mf_count++;
        end else m_frame++;
      end else m_pos++;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(line_valid, 1'b0, "R9", "line_valid in reset");
    rst_n = 1;
    @(negedge clk);
    chk(line_valid, 1'b0, "R9", "line_valid after reset");
    // directed: first ticked bit is frame 1 overhead (data link, valid 0 -> 1)
    step(1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk(line_mf_start, 1'b1, "R9", "first bit is frame 1 F");
    // directed idle gap
    for (int i = 0; i < 5; i++) step(0, 1, 1, 1, 0);
    // random run over four multiframes
    while (mf_count < 4) begin
      logic t = ($urandom % 4) != 0;
      step(t, ($urandom % 10) != 0, $urandom % 2, ($urandom % 10) < 7, $urandom % 2);
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule